// File: doc/BRIEF.md
# K-best Tree-Search PED Engine

This block performs the breadth-first tree search of a K-best list detector for a real-valued 2x2 MIMO link with 64-QAM. Each complex antenna stream is treated as two real dimensions, which gives a tree of four levels. Every node has eight children, one per real amplitude in {-7,-5,-3,-1,1,3,5,7}. The engine takes an upper-triangular real channel matrix and a rotated received vector, both in signed Q6.10. It walks the tree one level at a time, from the last row of the matrix up to the first. For every surviving path it computes the partial Euclidean distance (PED) of all eight children and feeds each child to a stable insertion list. That list keeps only the K smallest distances, and the K survivors become the parents of the next level.

The survivor count K is 8 or 16, chosen by a configuration input that is sampled with the start pulse. The number of children per level is therefore fixed: 8, 64, 8K and 8K. The time from start to done is fixed as well. When the fourth level has been sorted, the engine registers the final list on its outputs and raises a one-cycle done pulse. The list holds ascending PEDs, each paired with a 16-bit path tag.

Top module: `kbest_ped_engine`

## Requirements
- R1: After synchronous reset, done_o is 0, every bit of surv_vld_o is 0, and all survivor PED and tag outputs are 0.
- R2: Level n (n=1..4) decides dimension d=4-n, in the order 3, 2, 1, 0. The tag stores the amplitude index of dimension d in bits [3d+2:3d]. Index i stands for amplitude 2i-7. Tag bits [15:12] are always 0.
- R3: A child PED is the parent PED plus e*e/1024, rounded down, where e = y_d minus the sum over j>=d of r_dj*a_j. Here a_j is the integer amplitude fixed on the path, including the child's own symbol, and y and r are Q6.10 values. The result saturates at 32767. The root PED is 0. Matrix entry (i,j) sits at r_mat_i bits [(4i+j)*16+15:(4i+j)*16], and entries with j<i are ignored.
- R4: After each level, only the K smallest child PEDs are kept. When PEDs are equal, the child generated earlier wins. Children are generated in parent list order and, within a parent, by ascending amplitude index.
- R5: K is 16 when kmax_sel_i is 1 and 8 when it is 0, sampled on the clock edge that accepts start_i. Changes to kmax_sel_i during a search have no effect.
- R6: When done_o is high, exactly K survivor slots are valid. Valid slots form a prefix starting at slot 0, and their PEDs are in non-decreasing order. Slot s uses bits [16s+15:16s] of surv_ped_o and surv_sym_o.
- R7: done_o is a one-cycle pulse. It is high in the 332nd cycle after the start edge when K=16 (328 children plus 4 cycles), and in the 204th cycle when K=8 (200 children plus 4 cycles).
- R8: y_vec_i and r_mat_i are sampled with start_i. A start pulse, or any input change, during a search has no effect on that search's result or timing.
- R9: The survivor outputs hold their values between done pulses, whatever the inputs do while no search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search on one symbol vector (used only when idle) |
| kmax_sel_i | input | 1 | 1: keep 16 survivors, 0: keep 8 |
| y_vec_i | input | 64 | Rotated received vector, four Q6.10 values, element d at bits [16d+15:16d] |
| r_mat_i | input | 256 | Upper-triangular real channel matrix, Q6.10, entry (i,j) at bits [(4i+j)*16 +: 16] |
| done_o | output | 1 | One-cycle pulse when the final list is on the outputs |
| surv_ped_o | output | 256 | Final survivor PEDs, 16 slots of 16 bits |
| surv_sym_o | output | 256 | Final survivor path tags, 16 slots of 16 bits |
| surv_vld_o | output | 16 | Valid flag per survivor slot |

## Verification
The bench compares each search with a model that builds every child of a level, stable-sorts them and truncates to K. A wrong tie rule or an off-by-one limit would then return a different set or order of tags. An identity channel with a received vector on a lattice point must return that exact tag with PED 0, which exposes a swapped level order or a misplaced tag field. A received vector far outside the constellation forces every PED to the saturation value. A design that wraps instead of saturating would produce small, wrong distances, and a design with an unstable sort would reorder the ties. Runs with K changed, the inputs altered and a second start pulse issued mid-search must keep the original list and latency. A design that samples late would show a different list length or different distances.

// File: rtl/kbest_pkg.sv
package kbest_pkg;
  localparam int DW    = 16;
  localparam int FRAC  = 10;
  localparam int NDIM  = 4;
  localparam int NCAND = 8;
  localparam int KMAX  = 16;
  localparam int KMIN  = 8;

  // integer amplitude for candidate index: odd values centred on zero
  function automatic logic signed [7:0] cand_amp(input logic [$clog2(NCAND)-1:0] idx);
    return 8'(2 * int'(idx) - (NCAND - 1));
  endfunction
endpackage

// File: rtl/kbest_ped_calc.sv
module kbest_ped_calc
  import kbest_pkg::*;
#(
  parameter int W     = DW,
  parameter int FR    = FRAC,
  parameter int ND    = NDIM,
  parameter int NC    = NCAND
) (
  input  logic [$clog2(ND)-1:0]  row_i,
  input  logic [W-1:0]           y_row_i,
  input  logic [ND*W-1:0]        r_row_i,
  input  logic [W-1:0]           par_ped_i,
  input  logic [W-1:0]           par_sym_i,
  input  logic [$clog2(NC)-1:0]  cand_i,
  output logic [W-1:0]           child_ped_o,
  output logic [W-1:0]           child_sym_o
);
  localparam int  IW      = $clog2(NC);
  localparam longint SATV = (64'sd1 <<< (W - 1)) - 1;

  logic signed [31:0] acc, rj, aj;
  logic signed [63:0] sq, tot;

  always_comb begin
    acc = 32'($signed(y_row_i));
    for (int j = 0; j < ND; j++) begin
      rj = 32'($signed(r_row_i[j*W +: W]));
      if (j == int'(row_i))      aj = 32'(cand_amp(cand_i));
      else if (j > int'(row_i))  aj = 32'(cand_amp(par_sym_i[j*IW +: IW]));
      else                       aj = '0;
      acc = acc - rj * aj;
    end
    sq  = 64'(acc) * 64'(acc);
    tot = (sq >>> FR) + $signed({{(64-W){1'b0}}, par_ped_i});
    child_ped_o = (tot > SATV) ? W'(SATV) : tot[W-1:0];
    child_sym_o = par_sym_i;
    child_sym_o[int'(row_i)*IW +: IW] = cand_i;
  end
endmodule

// File: rtl/kbest_sorter.sv
module kbest_sorter #(
  parameter int W  = 16,
  parameter int KM = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_i,
  input  logic                    ins_i,
  input  logic [W-1:0]            ins_ped_i,
  input  logic [W-1:0]            ins_sym_i,
  input  logic [$clog2(KM+1)-1:0] lim_i,
  output logic [KM*W-1:0]         ped_o,
  output logic [KM*W-1:0]         sym_o,
  output logic [KM-1:0]           vld_o,
  output logic [$clog2(KM+1)-1:0] cnt_o
);
  localparam int CW = $clog2(KM + 1);

  logic [W-1:0]  ped_q [KM];
  logic [W-1:0]  sym_q [KM];
  logic [KM-1:0] vld_q;
  logic [KM-1:0] lt;

  // strict compare keeps equal entries ahead of the newcomer (stable)
  always_comb begin
    for (int p = 0; p < KM; p++) lt[p] = !vld_q[p] || (ins_ped_i < ped_q[p]);
  end

  for (genvar p = 0; p < KM; p++) begin : g_slot
    logic take_new, take_up, vld_n;
    if (p == 0) begin : g_head
      assign take_new = lt[0];
      assign take_up  = 1'b0;
      assign vld_n    = lt[0] | vld_q[0];
    end else begin : g_body
      assign take_new = lt[p] && !lt[p-1];
      assign take_up  = lt[p-1];
      assign vld_n    = take_new ? 1'b1 : (take_up ? vld_q[p-1] : vld_q[p]);
    end

    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        vld_q[p] <= 1'b0;
      end else if (ins_i) begin
        vld_q[p] <= vld_n && (p < int'(lim_i));
        if (take_new) begin
          ped_q[p] <= ins_ped_i;
          sym_q[p] <= ins_sym_i;
        end else if (take_up) begin
          ped_q[p] <= ped_q[(p == 0) ? 0 : p-1];
          sym_q[p] <= sym_q[(p == 0) ? 0 : p-1];
        end
      end
    end

    assign ped_o[p*W +: W] = ped_q[p];
    assign sym_o[p*W +: W] = sym_q[p];
  end

  assign vld_o = vld_q;

  always_comb begin
    cnt_o = '0;
    for (int p = 0; p < KM; p++) cnt_o = cnt_o + CW'(vld_q[p]);
  end
endmodule

// File: rtl/kbest_ped_engine.sv
module kbest_ped_engine
  import kbest_pkg::*;
#(
  parameter int W    = DW,
  parameter int FR   = FRAC,
  parameter int ND   = NDIM,
  parameter int NC   = NCAND,
  parameter int KHI  = KMAX,
  parameter int KLO  = KMIN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               kmax_sel_i,
  input  logic [ND*W-1:0]    y_vec_i,
  input  logic [ND*ND*W-1:0] r_mat_i,
  output logic               done_o,
  output logic [KHI*W-1:0]   surv_ped_o,
  output logic [KHI*W-1:0]   surv_sym_o,
  output logic [KHI-1:0]     surv_vld_o
);
  localparam int IW = $clog2(NC);
  localparam int LW = $clog2(ND);
  localparam int PW = $clog2(KHI);
  localparam int CW = $clog2(KHI + 1);

  typedef enum logic [1:0] {S_IDLE, S_EXP, S_LOAD, S_FIN} st_t;

  st_t               st;
  logic [LW-1:0]     lvl, row;
  logic [PW-1:0]     pidx;
  logic [IW-1:0]     cidx;
  logic [CW-1:0]     npar, klim;
  logic [ND*W-1:0]   y_q;
  logic [ND*ND*W-1:0] r_q;
  logic [W-1:0]      par_ped [KHI];
  logic [W-1:0]      par_sym [KHI];

  logic [W-1:0]      ch_ped, ch_sym;
  logic [KHI*W-1:0]  srt_ped, srt_sym;
  logic [KHI-1:0]    srt_vld;
  logic [CW-1:0]     srt_cnt;
  logic              go, srt_clr, last_c, last_p;

  assign go      = (st == S_IDLE) && start_i;
  assign srt_clr = go || (st == S_LOAD);
  assign row     = LW'(ND - 1) - lvl;
  assign last_c  = (cidx == IW'(NC - 1));
  assign last_p  = (CW'(pidx) == npar - CW'(1));

  kbest_ped_calc #(.W(W), .FR(FR), .ND(ND), .NC(NC)) u_calc (
    .row_i       (row),
    .y_row_i     (y_q[int'(row)*W +: W]),
    .r_row_i     (r_q[int'(row)*ND*W +: ND*W]),
    .par_ped_i   (par_ped[pidx]),
    .par_sym_i   (par_sym[pidx]),
    .cand_i      (cidx),
    .child_ped_o (ch_ped),
    .child_sym_o (ch_sym)
  );

  kbest_sorter #(.W(W), .KM(KHI)) u_sort (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (srt_clr),
    .ins_i     (st == S_EXP),
    .ins_ped_i (ch_ped),
    .ins_sym_i (ch_sym),
    .lim_i     (klim),
    .ped_o     (srt_ped),
    .sym_o     (srt_sym),
    .vld_o     (srt_vld),
    .cnt_o     (srt_cnt)
  );

  // parent list storage: plain memory, no reset
  always_ff @(posedge clk) begin
    if (go) begin
      par_ped[0] <= '0;
      par_sym[0] <= '0;
    end else if (st == S_LOAD) begin
      for (int k = 0; k < KHI; k++) begin
        par_ped[k] <= srt_ped[k*W +: W];
        par_sym[k] <= srt_sym[k*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      lvl        <= '0;
      pidx       <= '0;
      cidx       <= '0;
      npar       <= '0;
      klim       <= '0;
      y_q        <= '0;
      r_q        <= '0;
      done_o     <= 1'b0;
      surv_ped_o <= '0;
      surv_sym_o <= '0;
      surv_vld_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          klim <= kmax_sel_i ? CW'(KHI) : CW'(KLO);
          y_q  <= y_vec_i;
          r_q  <= r_mat_i;
          lvl  <= '0;
          pidx <= '0;
          cidx <= '0;
          npar <= CW'(1);
          st   <= S_EXP;
        end
        S_EXP: begin
          if (last_c) begin
            cidx <= '0;
            if (last_p) st <= (lvl == LW'(ND - 1)) ? S_FIN : S_LOAD;
            else        pidx <= pidx + PW'(1);
          end else begin
            cidx <= cidx + IW'(1);
          end
        end
        S_LOAD: begin
          npar <= srt_cnt;
          lvl  <= lvl + LW'(1);
          pidx <= '0;
          cidx <= '0;
          st   <= S_EXP;
        end
        S_FIN: begin
          surv_ped_o <= srt_ped;
          surv_sym_o <= srt_sym;
          surv_vld_o <= srt_vld;
          done_o     <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kbest_ped_engine_chk.sv
module kbest_ped_engine_chk
  import kbest_pkg::*;
#(
  parameter int W   = DW,
  parameter int ND  = NDIM,
  parameter int NC  = NCAND,
  parameter int KHI = KMAX,
  parameter int KLO = KMIN
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             kmax_sel_i,
  input logic             done_o,
  input logic [KHI*W-1:0] surv_ped_o,
  input logic [KHI-1:0]   surv_vld_o
);
  function automatic int exp_lat(input int k);
    int n, tot;
    n = 1;
    tot = 0;
    for (int l = 0; l < ND; l++) begin
      tot = tot + n * NC;
      n = (n * NC < k) ? n * NC : k;
    end
    return tot + ND;
  endfunction

  localparam int LAT_HI = exp_lat(KHI);
  localparam int LAT_LO = exp_lat(KLO);

  logic        run, kq;
  logic [15:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      kq  <= 1'b0;
      cyc <= '0;
    end else if (start_i && (!run || done_o)) begin
      run <= 1'b1;
      kq  <= kmax_sel_i;
      cyc <= '0;
    end else if (done_o) begin
      run <= 1'b0;
    end else if (run) begin
      cyc <= cyc + 16'd1;
    end
  end

  // R7: fixed start-to-done latency
  p_done_latency_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (run && int'(cyc) == (kq ? LAT_HI : LAT_LO)));

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6, R5: list length equals the K sampled at start
  p_list_count_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($countones(surv_vld_o) == (kq ? KHI : KLO)));

  for (genvar p = 0; p < KHI - 1; p++) begin : g_pair
    // R6: valid slots form a prefix
    p_prefix_r6: assert property (@(posedge clk) disable iff (rst)
      surv_vld_o[p+1] |-> surv_vld_o[p]);
    // R6: ascending order of final distances
    p_sorted_r6: assert property (@(posedge clk) disable iff (rst)
      (done_o && surv_vld_o[p+1]) |-> (surv_ped_o[p*W +: W] <= surv_ped_o[(p+1)*W +: W]));
  end
endmodule

bind kbest_ped_engine kbest_ped_engine_chk #(
  .W(W), .ND(ND), .NC(NC), .KHI(KHI), .KLO(KLO)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .kmax_sel_i (kmax_sel_i),
  .done_o     (done_o),
  .surv_ped_o (surv_ped_o),
  .surv_vld_o (surv_vld_o)
);

// File: tb/kbest_ped_engine_tb.sv
`timescale 1ns/1ps
module kbest_ped_engine_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         ksel = 1'b0;
  logic [63:0]  yv = '0;
  logic [255:0] rm = '0;
  logic         done;
  logic [255:0] sped, ssym;
  logic [15:0]  svld;

  int n_chk = 0;
  int n_err = 0;
  int exp_ped [16];
  int exp_sym [16];
  int exp_n;

  always #2 clk = ~clk;

  kbest_ped_engine u_dut (
    .clk(clk), .rst(rst), .start_i(start), .kmax_sel_i(ksel),
    .y_vec_i(yv), .r_mat_i(rm), .done_o(done),
    .surv_ped_o(sped), .surv_sym_o(ssym), .surv_vld_o(svld)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // reference: build every child, stable sort, keep the K smallest
  task automatic ref_run(input bit k16, input logic [63:0] y, input logic [255:0] r);
    int kk, np, nc, row, idx, key_p, key_s, j2;
    int pp [16];
    int ps [16];
    int cp [128];
    int cs [128];
    longint acc, v;
    kk = k16 ? 16 : 8;
    np = 1; pp[0] = 0; ps[0] = 0;
    for (int lv = 0; lv < 4; lv++) begin
      row = 3 - lv; nc = 0;
      for (int a = 0; a < np; a++) begin
        for (int c = 0; c < 8; c++) begin
          acc = longint'($signed(y[row*16 +: 16]));
          for (int j = row; j < 4; j++) begin
            idx = (j == row) ? c : ((ps[a] >> (3*j)) & 7);
            acc = acc - longint'($signed(r[(row*4+j)*16 +: 16])) * longint'(2*idx - 7);
          end
          v = ((acc * acc) >>> 10) + longint'(pp[a]);
          cp[nc] = (v > 32767) ? 32767 : int'(v);
          cs[nc] = ps[a] | (c << (3*row));
          nc++;
        end
      end
      for (int i = 1; i < nc; i++) begin
        key_p = cp[i]; key_s = cs[i]; j2 = i - 1;
        while (j2 >= 0 && cp[j2] > key_p) begin
          cp[j2+1] = cp[j2]; cs[j2+1] = cs[j2]; j2--;
        end
        cp[j2+1] = key_p; cs[j2+1] = key_s;
      end
      np = (nc < kk) ? nc : kk;
      for (int i = 0; i < np; i++) begin pp[i] = cp[i]; ps[i] = cs[i]; end
    end
    exp_n = np;
    for (int i = 0; i < 16; i++) begin
      exp_ped[i] = (i < np) ? pp[i] : 0;
      exp_sym[i] = (i < np) ? ps[i] : 0;
    end
  endtask

  task automatic cmp_list(input string req);
    for (int e = 0; e < 16; e++) begin
      check(svld[e] == (e < exp_n), req, $sformatf("slot %0d valid", e), svld[e], (e < exp_n));
      if (e < exp_n) begin
        check(int'(sped[e*16 +: 16]) == exp_ped[e], req, $sformatf("slot %0d ped", e),
              sped[e*16 +: 16], exp_ped[e]);
        check(int'(ssym[e*16 +: 16]) == exp_sym[e], req, $sformatf("slot %0d tag", e),
              ssym[e*16 +: 16], exp_sym[e]);
      end
    end
  endtask

  task automatic do_run(input bit k16, input logic [63:0] y, input logic [255:0] r,
                        input bit perturb, input string req);
    int cnt, lat;
    bit seen;
    lat = k16 ? 332 : 204;
    ref_run(k16, y, r);
    @(negedge clk);
    start = 1'b1; ksel = k16; yv = y; rm = r;
    @(negedge clk);
    start = 1'b0; cnt = 0; seen = 1'b0;
    while (cnt < 2000) begin
      if (done) begin seen = 1'b1; break; end
      if (perturb && cnt == 5) begin ksel = !k16; yv = ~y; rm = ~r; end
      start = (perturb && cnt == 10);
      cnt++;
      @(negedge clk);
    end
    start = 1'b0;
    check(seen, "R7", "done seen before timeout", seen, 1);
    check(cnt == lat, "R7", "latency", cnt, lat);
    cmp_list(req);
    @(negedge clk);
    check(!done, "R7", "done pulse width", done, 0);
  endtask

  function automatic logic [255:0] ident_r();
    logic [255:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) r[(i*4+i)*16 +: 16] = 16'd1024;
    return r;
  endfunction

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [63:0]  y;
    logic [255:0] r;
    int tv, exp_tag;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(svld == '0, "R1", "valid after reset", svld, 0);
    check(sped == '0 && ssym == '0, "R1", "list after reset", sped[15:0], 0);

    // R2: identity channel, y on a lattice point -> exact tag with PED 0
    y = '0;
    tv = 0;
    exp_tag = 0;
    for (int d = 0; d < 4; d++) begin
      tv = (d * 5 + 3) % 8;
      y[d*16 +: 16] = 16'((2*tv - 7) * 1024);
      exp_tag = exp_tag | (tv << (3*d));
    end
    for (int k = 0; k < 2; k++) begin
      do_run(k[0], y, ident_r(), 1'b0, "R3 R4");
      check(int'(ssym[15:0]) == exp_tag, "R2", "best tag", ssym[15:0], exp_tag);
      check(sped[15:0] == 16'd0, "R2", "best ped", sped[15:0], 0);
    end

    // R4 ties: y at origin, identity channel -> minimum 4 * 1024 with many ties
    do_run(1'b1, '0, ident_r(), 1'b0, "R4");
    check(sped[15:0] == 16'd4096, "R3", "origin min ped", sped[15:0], 4096);

    // R3 saturation: far outside constellation
    do_run(1'b0, {4{16'h7FFF}}, ident_r(), 1'b0, "R3 R4");
    check(sped[15:0] == 16'd32767, "R3", "saturated ped", sped[15:0], 32767);

    // R5, R8: mid-search changes and a second start are ignored
    r = '0;
    for (int i = 0; i < 16; i++) r[i*16 +: 16] = 16'(int'($urandom_range(0, 4096)) - 2048);
    for (int d = 0; d < 4; d++) y[d*16 +: 16] = 16'(int'($urandom_range(0, 16384)) - 8192);
    do_run(1'b1, y, r, 1'b1, "R5 R8");
    do_run(1'b0, y, r, 1'b1, "R5 R8");

    // R9: outputs hold while no search completes
    repeat (20) begin
      @(negedge clk);
      yv = {$urandom, $urandom};
      ksel = !ksel;
    end
    cmp_list("R9");

    // R3 R4 R6: random channels (lower triangle garbage must be ignored)
    for (int t = 0; t < 24; t++) begin
      for (int i = 0; i < 16; i++) r[i*16 +: 16] = 16'(int'($urandom_range(0, 4096)) - 2048);
      for (int d = 0; d < 4; d++) y[d*16 +: 16] = 16'(int'($urandom_range(0, 16384)) - 8192);
      do_run(t[0], y, r, 1'b0, "R3 R4 R6");
    end

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule